// File: doc/BRIEF.md
# PC Card Flash Array Interface Controller

This block sits between a 16-bit PC Card memory host and a bank of byte-wide flash devices that are fitted in pairs. Each pair holds the even byte in one device and the odd byte in the other, so every pair forms one 16-bit word store. The host's two card enables and its lowest address bit select the byte lanes. A word host uses both lanes at once. An 8-bit host can reach every byte through the low lane.

The upper host address bits pick one pair, and the middle bits go to all devices as the word address. When the attribute-plane select is low, the access goes to a small separate memory instead, which is populated at even byte addresses only. A write-protect switch blocks every write strobe to the flash array. The per-device ready lines are combined into one card ready flag, which crosses into the controller clock through a two-flop synchronizer. An active-high card reset deselects everything. The wait and battery-detect outputs are held inactive.

Top module: `flashCardTop`

## Requirements
- R1: With both card enables low the access is word-wide and A0 is ignored. The even device (index 2p) and the odd device (index 2p+1) of pair p are both selected. Read data appears as even byte on hostDataOut[7:0] and odd byte on [15:8]. Write data goes out as hostDataIn[7:0] to the even device and hostDataIn[15:8] to the odd device.
- R2: With ce1N low and ce2N high, A0=0 selects only the even device, and its data is on the low lane. A0=1 selects only the odd device, and its read data is steered onto hostDataOut[7:0]. Odd write data is then taken from hostDataIn[7:0].
- R3: With ce1N high and ce2N low, only the odd device is selected and its data uses hostDataOut[15:8]. With both enables high, no device is selected and no lane is driven.
- R4: hostAddr[25:22] is the pair index and hostAddr[21:1] is passed unchanged to devAddr. A pair index at or above PAIR_COUNT (default 10) selects no device and drives no lane.
- R5: When regN is low, no flash device is selected. The attribute memory is selected only for accesses that include the even byte, with attrAddr = hostAddr[10:1]. Its data uses the low lane only, and an odd-byte-only attribute access selects nothing.
- R6: While wpSwitch is high, every flash write strobe stays high, although chip selects still follow the decode. Attribute-plane writes are not blocked.
- R7: A device or attribute read strobe (active low) is asserted only while oeN is low and weN is high. A write strobe is asserted while weN is low, even if oeN is low. The host lane drivers are on only during a read strobe.
- R8: cardReady is high only when every devReady bit is high. It follows a change of the combined ready after two rising clock edges, and it is low while cardRst is high.
- R9: While cardRst is high, all chip selects, read strobes and write strobes are high, and no host lane is driven.
- R10: waitN, bvd1 and bvd2 are always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (ready synchronizer, checks) |
| cardRst | input | 1 | Card reset, active high |
| hostAddr | input | 26 | Host byte address |
| ce1N | input | 1 | Even-byte card enable, active low |
| ce2N | input | 1 | Odd-byte card enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| regN | input | 1 | Attribute-plane select, active low |
| wpSwitch | input | 1 | Write-protect switch, high = protected |
| hostDataIn | input | 16 | Write data from host |
| hostDataOut | output | 16 | Read data to host |
| hostDriveLow | output | 1 | Drive enable for the low host lane |
| hostDriveHigh | output | 1 | Drive enable for the high host lane |
| waitN | output | 1 | Wait request, held high |
| bvd1 | output | 1 | Battery detect 1, held high |
| bvd2 | output | 1 | Battery detect 2, held high |
| cardReady | output | 1 | Combined, synchronized ready |
| devAddr | output | 21 | Word address to all flash devices |
| devCsN | output | 20 | Per-device chip select, active low |
| devOeN | output | 20 | Per-device read strobe, active low |
| devWeN | output | 20 | Per-device write strobe, active low |
| devReady | input | 20 | Per-device ready, high = idle |
| flashEvenRd | input | 8 | Shared read bus of even devices |
| flashOddRd | input | 8 | Shared read bus of odd devices |
| flashEvenWr | output | 8 | Write data to even devices |
| flashOddWr | output | 8 | Write data to odd devices |
| attrAddr | output | 10 | Attribute memory address |
| attrCsN | output | 1 | Attribute memory select, active low |
| attrOeN | output | 1 | Attribute read strobe, active low |
| attrWeN | output | 1 | Attribute write strobe, active low |
| attrRd | input | 8 | Attribute read data |
| attrWr | output | 8 | Attribute write data |

## Verification
Some rules are checked at every clock edge. Write lockout under protection is one. Read and write strobes are never both low on a device, and no more than two devices are selected at once. An attribute access never selects a flash device, and the lanes are never driven during a write. cardReady never rises without the combined ready having been high two edges earlier, and reset deselects everything. Those checks cannot show that the decode picks the right device, which needs the bench's scenarios. The same holds for lane steering in each byte mode, the value on each lane, the unfitted-pair boundary, address routing and the exact synchronizer latency.

// File: rtl/flashCardPkg.sv
package flashCardPkg;

  // Strobes handed from the decode to the lane datapath.
  typedef struct packed {
    logic rdPhase;   // read strobe window (OE# low, WE# high)
    logic wrPhase;   // write strobe window (WE# low)
    logic evenSel;   // even byte takes part
    logic oddSel;    // odd byte takes part
    logic oddToLow;  // odd byte steered onto the low lane
    logic flashHit;  // fitted flash pair addressed
    logic attrHit;   // attribute plane addressed (even byte)
  } laneStrobe_t;

endpackage

// File: rtl/flashCardCtrl.sv
module flashCardCtrl
  import flashCardPkg::*;
#(
  parameter int PAIR_COUNT = 10,
  parameter int DEV_AW     = 21,
  parameter int PAIR_AW    = 4,
  parameter int ATTR_AW    = 10,
  parameter bit HAS_WP     = 1'b1,
  localparam int DEV_COUNT = 2 * PAIR_COUNT,
  localparam int HOST_AW   = DEV_AW + PAIR_AW + 1
) (
  input  logic                 clk,
  input  logic                 cardRst,
  input  logic [HOST_AW-1:0]   hostAddr,
  input  logic                 ce1N,
  input  logic                 ce2N,
  input  logic                 oeN,
  input  logic                 weN,
  input  logic                 regN,
  input  logic                 wpSwitch,
  output laneStrobe_t          strb,
  output logic [DEV_AW-1:0]    devAddr,
  output logic [DEV_COUNT-1:0] devCsN,
  output logic [DEV_COUNT-1:0] devOeN,
  output logic [DEV_COUNT-1:0] devWeN,
  output logic [ATTR_AW-1:0]   attrAddr,
  output logic                 attrCsN,
  output logic                 attrOeN,
  output logic                 attrWeN
);

  localparam logic [PAIR_AW:0] FIT_LIMIT = (PAIR_AW + 1)'(PAIR_COUNT);

  logic [PAIR_AW-1:0] pairIdx;
  logic a0, active, wordAcc, lowOnly, highOnly, pairFitted, wpEff;

  assign pairIdx    = hostAddr[HOST_AW-1 -: PAIR_AW];
  assign a0         = hostAddr[0];
  assign devAddr    = hostAddr[DEV_AW:1];
  assign attrAddr   = hostAddr[ATTR_AW:1];
  assign pairFitted = {1'b0, pairIdx} < FIT_LIMIT;
  assign wpEff      = wpSwitch & HAS_WP;

  always_comb begin
    active   = !cardRst && !(ce1N && ce2N);
    wordAcc  = !ce1N && !ce2N;
    lowOnly  = !ce1N && ce2N;
    highOnly = ce1N && !ce2N;
    strb.evenSel  = active && (wordAcc || (lowOnly && !a0));
    strb.oddSel   = active && (wordAcc || highOnly || (lowOnly && a0));
    strb.oddToLow = active && lowOnly && a0;
    strb.rdPhase  = active && !oeN && weN;
    strb.wrPhase  = active && !weN;
    strb.flashHit = active && regN && pairFitted;
    strb.attrHit  = active && !regN && strb.evenSel;
  end

  generate
    for (genvar p = 0; p < PAIR_COUNT; p++) begin : g_pair
      logic pairHit, evenCs, oddCs;
      assign pairHit = strb.flashHit && (pairIdx == PAIR_AW'(p));
      assign evenCs  = pairHit && strb.evenSel;
      assign oddCs   = pairHit && strb.oddSel;
      assign devCsN[2*p]   = !evenCs;
      assign devCsN[2*p+1] = !oddCs;
      assign devOeN[2*p]   = !(evenCs && strb.rdPhase);
      assign devOeN[2*p+1] = !(oddCs && strb.rdPhase);
      assign devWeN[2*p]   = !(evenCs && strb.wrPhase && !wpEff);
      assign devWeN[2*p+1] = !(oddCs && strb.wrPhase && !wpEff);
    end
  endgenerate

  assign attrCsN = !strb.attrHit;
  assign attrOeN = !(strb.attrHit && strb.rdPhase);
  assign attrWeN = !(strb.attrHit && strb.wrPhase);

  // R6
  wp_lockout_chk: assert property (@(posedge clk) disable iff (cardRst)
    (wpSwitch && HAS_WP) |-> (&devWeN));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (cardRst)
    ((~devOeN) & (~devWeN)) == '0);

  // R4
  pair_width_chk: assert property (@(posedge clk) disable iff (cardRst)
    $countones(~devCsN) <= 2);

  // R5
  attr_isolate_chk: assert property (@(posedge clk) disable iff (cardRst)
    !attrCsN |-> (&devCsN));

  // R9
  always_ff @(posedge clk) begin
    if (cardRst) begin
      rst_deselect_chk: assert ((&devCsN) && (&devWeN) && attrCsN && attrWeN);
    end
  end

endmodule

// File: rtl/flashCardData.sv
module flashCardData
  import flashCardPkg::*;
(
  input  logic        clk,
  input  logic        cardRst,
  input  laneStrobe_t strb,
  input  logic [15:0] hostDataIn,
  input  logic [7:0]  flashEvenRd,
  input  logic [7:0]  flashOddRd,
  input  logic [7:0]  attrRd,
  output logic [15:0] hostDataOut,
  output logic        hostDriveLow,
  output logic        hostDriveHigh,
  output logic [7:0]  flashEvenWr,
  output logic [7:0]  flashOddWr,
  output logic [7:0]  attrWr
);

  always_comb begin
    hostDriveLow  = strb.rdPhase &&
                    (strb.attrHit || (strb.flashHit && (strb.evenSel || strb.oddToLow)));
    hostDriveHigh = strb.rdPhase && strb.flashHit && strb.oddSel && !strb.oddToLow;

    hostDataOut = '0;
    if (hostDriveLow) begin
      if (strb.attrHit)       hostDataOut[7:0] = attrRd;
      else if (strb.oddToLow) hostDataOut[7:0] = flashOddRd;
      else                    hostDataOut[7:0] = flashEvenRd;
    end
    if (hostDriveHigh) hostDataOut[15:8] = flashOddRd;
  end

  assign flashEvenWr = hostDataIn[7:0];
  assign flashOddWr  = strb.oddToLow ? hostDataIn[7:0] : hostDataIn[15:8];
  assign attrWr      = hostDataIn[7:0];

  // R7
  no_drive_on_write_chk: assert property (@(posedge clk) disable iff (cardRst)
    strb.wrPhase |-> !(hostDriveLow || hostDriveHigh));

  // R5
  attr_low_lane_chk: assert property (@(posedge clk) disable iff (cardRst)
    strb.attrHit |-> !hostDriveHigh);

endmodule

// File: rtl/flashCardReady.sv
module flashCardReady #(
  parameter int DEV_COUNT   = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 cardRst,
  input  logic [DEV_COUNT-1:0] devReady,
  output logic                 cardReady
);

  logic readyAll;
  logic [SYNC_STAGES-1:0] syncQ;

  assign readyAll = &devReady;

  always_ff @(posedge clk or posedge cardRst) begin
    if (cardRst) syncQ <= '0;
    else         syncQ <= {syncQ[SYNC_STAGES-2:0], readyAll};
  end

  assign cardReady = syncQ[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES == 2) begin : g_lat_chk
      // R8
      ready_origin_chk: assert property (@(posedge clk) disable iff (cardRst)
        cardReady |-> $past(readyAll, 2));
    end
  endgenerate

endmodule

// File: rtl/flashCardTop.sv
module flashCardTop
  import flashCardPkg::*;
#(
  parameter int PAIR_COUNT  = 10,
  parameter int DEV_AW      = 21,
  parameter int PAIR_AW     = 4,
  parameter int ATTR_AW     = 10,
  parameter bit HAS_WP      = 1'b1,
  parameter int SYNC_STAGES = 2,
  localparam int DEV_COUNT  = 2 * PAIR_COUNT,
  localparam int HOST_AW    = DEV_AW + PAIR_AW + 1
) (
  input  logic                 clk,
  input  logic                 cardRst,
  input  logic [HOST_AW-1:0]   hostAddr,
  input  logic                 ce1N,
  input  logic                 ce2N,
  input  logic                 oeN,
  input  logic                 weN,
  input  logic                 regN,
  input  logic                 wpSwitch,
  input  logic [15:0]          hostDataIn,
  output logic [15:0]          hostDataOut,
  output logic                 hostDriveLow,
  output logic                 hostDriveHigh,
  output logic                 waitN,
  output logic                 bvd1,
  output logic                 bvd2,
  output logic                 cardReady,
  output logic [DEV_AW-1:0]    devAddr,
  output logic [DEV_COUNT-1:0] devCsN,
  output logic [DEV_COUNT-1:0] devOeN,
  output logic [DEV_COUNT-1:0] devWeN,
  input  logic [DEV_COUNT-1:0] devReady,
  input  logic [7:0]           flashEvenRd,
  input  logic [7:0]           flashOddRd,
  output logic [7:0]           flashEvenWr,
  output logic [7:0]           flashOddWr,
  output logic [ATTR_AW-1:0]   attrAddr,
  output logic                 attrCsN,
  output logic                 attrOeN,
  output logic                 attrWeN,
  input  logic [7:0]           attrRd,
  output logic [7:0]           attrWr
);

  laneStrobe_t strb;

  assign waitN = 1'b1;
  assign bvd1  = 1'b1;
  assign bvd2  = 1'b1;

  flashCardCtrl #(
    .PAIR_COUNT(PAIR_COUNT), .DEV_AW(DEV_AW), .PAIR_AW(PAIR_AW),
    .ATTR_AW(ATTR_AW), .HAS_WP(HAS_WP)
  ) ctrl_i (
    .clk(clk), .cardRst(cardRst), .hostAddr(hostAddr),
    .ce1N(ce1N), .ce2N(ce2N), .oeN(oeN), .weN(weN), .regN(regN),
    .wpSwitch(wpSwitch), .strb(strb), .devAddr(devAddr),
    .devCsN(devCsN), .devOeN(devOeN), .devWeN(devWeN),
    .attrAddr(attrAddr), .attrCsN(attrCsN), .attrOeN(attrOeN), .attrWeN(attrWeN)
  );

  flashCardData data_i (
    .clk(clk), .cardRst(cardRst), .strb(strb), .hostDataIn(hostDataIn),
    .flashEvenRd(flashEvenRd), .flashOddRd(flashOddRd), .attrRd(attrRd),
    .hostDataOut(hostDataOut), .hostDriveLow(hostDriveLow),
    .hostDriveHigh(hostDriveHigh), .flashEvenWr(flashEvenWr),
    .flashOddWr(flashOddWr), .attrWr(attrWr)
  );

  flashCardReady #(
    .DEV_COUNT(DEV_COUNT), .SYNC_STAGES(SYNC_STAGES)
  ) ready_i (
    .clk(clk), .cardRst(cardRst), .devReady(devReady), .cardReady(cardReady)
  );

endmodule

// File: tb/flashCardTop_tb_top.sv
module flashCardTop_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NDEV = 20;

  typedef struct packed {
    logic regN, ce1N, ce2N, oeN, weN, wp;
    logic [3:0]  pair;
    logic        a0;
    logic [19:0] expCsN;
    logic        expRd, expWr, expAttr, expLow, expHigh;
    logic [7:0]  expLowVal, expHighVal;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    // R1 word read pair 0
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,4'd0, 1'b0,20'hFFFFC,1'b1,1'b0,1'b0,1'b1,1'b1,8'h5A,8'hC3,4'd1},
    // R1 word read pair 3, A0 ignored
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,4'd3, 1'b1,20'hFFF3F,1'b1,1'b0,1'b0,1'b1,1'b1,8'h5A,8'hC3,4'd1},
    // R2 low-lane byte, even
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,4'd2, 1'b0,20'hFFFEF,1'b1,1'b0,1'b0,1'b1,1'b0,8'h5A,8'h00,4'd2},
    // R2 low-lane byte, odd steered low
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,4'd2, 1'b1,20'hFFFDF,1'b1,1'b0,1'b0,1'b1,1'b0,8'hC3,8'h00,4'd2},
    // R3 high-lane odd byte
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,4'd1, 1'b0,20'hFFFF7,1'b1,1'b0,1'b0,1'b0,1'b1,8'h00,8'hC3,4'd3},
    // R3 both enables high
    '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,4'd0, 1'b0,20'hFFFFF,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,4'd3},
    // R4 word write, last fitted pair
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,4'd9, 1'b0,20'h3FFFF,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00,4'd4},
    // R6 same write, protected
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,4'd9, 1'b0,20'h3FFFF,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,4'd6},
    // R7 OE# and WE# both low: write wins
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0, 1'b0,20'hFFFFC,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00,4'd7},
    // R4 unfitted pair 12
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,4'd12,1'b0,20'hFFFFF,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,4'd4},
    // R5 attribute word read
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,4'd0, 1'b0,20'hFFFFF,1'b1,1'b0,1'b1,1'b1,1'b0,8'h7E,8'h00,4'd5},
    // R5 attribute odd byte only
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,4'd0, 1'b1,20'hFFFFF,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,4'd5},
    // R7 selected but idle strobes
    '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,4'd0, 1'b0,20'hFFFFD,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,4'd7},
    // R4 first unfitted pair 10
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,4'd10,1'b0,20'hFFFFF,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,4'd4}
  };

  logic clk = 1'b0;
  logic cardRst;
  logic [25:0] hostAddr;
  logic ce1N, ce2N, oeN, weN, regN, wpSwitch;
  logic [15:0] hostDataIn, hostDataOut;
  logic hostDriveLow, hostDriveHigh, waitN, bvd1, bvd2, cardReady;
  logic [20:0] devAddr;
  logic [NDEV-1:0] devCsN, devOeN, devWeN, devReady;
  logic [7:0] flashEvenRd, flashOddRd, flashEvenWr, flashOddWr, attrRd, attrWr;
  logic [9:0] attrAddr;
  logic attrCsN, attrOeN, attrWeN;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flashCardTop dut_i (
    .clk(clk), .cardRst(cardRst), .hostAddr(hostAddr), .ce1N(ce1N), .ce2N(ce2N),
    .oeN(oeN), .weN(weN), .regN(regN), .wpSwitch(wpSwitch), .hostDataIn(hostDataIn),
    .hostDataOut(hostDataOut), .hostDriveLow(hostDriveLow), .hostDriveHigh(hostDriveHigh),
    .waitN(waitN), .bvd1(bvd1), .bvd2(bvd2), .cardReady(cardReady), .devAddr(devAddr),
    .devCsN(devCsN), .devOeN(devOeN), .devWeN(devWeN), .devReady(devReady),
    .flashEvenRd(flashEvenRd), .flashOddRd(flashOddRd), .flashEvenWr(flashEvenWr),
    .flashOddWr(flashOddWr), .attrAddr(attrAddr), .attrCsN(attrCsN), .attrOeN(attrOeN),
    .attrWeN(attrWeN), .attrRd(attrRd), .attrWr(attrWr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic c1, input logic c2, input logic o,
                       input logic w, input logic wp, input logic [3:0] pair,
                       input logic [20:0] word, input logic a0);
    regN = r; ce1N = c1; ce2N = c2; oeN = o; weN = w; wpSwitch = wp;
    hostAddr = {pair, word, a0};
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    cardRst = 1'b1;
    devReady = '1;
    flashEvenRd = 8'h5A; flashOddRd = 8'hC3; attrRd = 8'h7E;
    hostDataIn = 16'hB4E1;
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 21'h00123, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset deselects a live word read
    chk(&devCsN && &devOeN && &devWeN, "R9", "dev strobes in reset", {12'h0, devCsN}, 32'hFFFFF);
    chk(!hostDriveLow && !hostDriveHigh && attrCsN, "R9", "drive in reset",
        {30'h0, hostDriveHigh, hostDriveLow}, 32'h0);
    // R8 low during reset
    chk(cardReady == 1'b0, "R8", "ready in reset", {31'h0, cardReady}, 32'h0);
    // R10 held lines
    chk(waitN && bvd1 && bvd2, "R10", "wait/bvd", {29'h0, waitN, bvd1, bvd2}, 32'h7);

    cardRst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      string rq;
      logic [19:0] eOe, eWe;
      rq = $sformatf("R%0d", VECS[i].req);
      drive(VECS[i].regN, VECS[i].ce1N, VECS[i].ce2N, VECS[i].oeN, VECS[i].weN,
            VECS[i].wp, VECS[i].pair, 21'h00123, VECS[i].a0);
      #(CLK_PERIOD/4);
      eOe = VECS[i].expRd ? VECS[i].expCsN : 20'hFFFFF;
      eWe = VECS[i].expWr ? VECS[i].expCsN : 20'hFFFFF;
      chk(devCsN == VECS[i].expCsN, rq, $sformatf("vec%0d devCsN", i), {12'h0, devCsN}, {12'h0, VECS[i].expCsN});
      chk(devOeN == eOe, rq, $sformatf("vec%0d devOeN", i), {12'h0, devOeN}, {12'h0, eOe});
      chk(devWeN == eWe, rq, $sformatf("vec%0d devWeN", i), {12'h0, devWeN}, {12'h0, eWe});
      chk({attrCsN, attrOeN, attrWeN} ==
          {!VECS[i].expAttr, !(VECS[i].expAttr && VECS[i].expRd), !(VECS[i].expAttr && VECS[i].expWr)},
          rq, $sformatf("vec%0d attr strobes", i), {29'h0, attrCsN, attrOeN, attrWeN},
          {29'h0, !VECS[i].expAttr, !(VECS[i].expAttr && VECS[i].expRd), !(VECS[i].expAttr && VECS[i].expWr)});
      chk({hostDriveLow, hostDriveHigh} == {VECS[i].expLow, VECS[i].expHigh}, rq,
          $sformatf("vec%0d lane drive", i), {30'h0, hostDriveLow, hostDriveHigh},
          {30'h0, VECS[i].expLow, VECS[i].expHigh});
      if (VECS[i].expLow)
        chk(hostDataOut[7:0] == VECS[i].expLowVal, rq, $sformatf("vec%0d low lane", i),
            {24'h0, hostDataOut[7:0]}, {24'h0, VECS[i].expLowVal});
      if (VECS[i].expHigh)
        chk(hostDataOut[15:8] == VECS[i].expHighVal, rq, $sformatf("vec%0d high lane", i),
            {24'h0, hostDataOut[15:8]}, {24'h0, VECS[i].expHighVal});
      @(negedge clk);
    end

    // R1 word write lanes
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 21'h00123, 1'b0);
    #(CLK_PERIOD/4);
    chk(flashEvenWr == 8'hE1 && flashOddWr == 8'hB4, "R1", "word write data",
        {16'h0, flashOddWr, flashEvenWr}, 32'hB4E1);
    @(negedge clk);
    // R2 odd byte written from low lane
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 21'h00123, 1'b1);
    #(CLK_PERIOD/4);
    chk(flashOddWr == 8'hE1 && devWeN == 20'hFFFFD, "R2", "odd write via low lane",
        {4'h0, devWeN, flashOddWr}, {4'h0, 20'hFFFFD, 8'hE1});
    @(negedge clk);
    // R4 device address routing
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd5, 21'h1ABCD, 1'b1);
    #(CLK_PERIOD/4);
    chk(devAddr == 21'h1ABCD && devCsN == 20'hFF3FF, "R4", "devAddr/pair 5",
        {11'h0, devAddr}, {11'h0, 21'h1ABCD});
    @(negedge clk);
    // R5 attribute address, R6 attribute write under protection
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 21'h002A5, 1'b0);
    #(CLK_PERIOD/4);
    chk(attrAddr == 10'h2A5, "R5", "attrAddr", {22'h0, attrAddr}, {22'h0, 10'h2A5});
    chk(attrWeN == 1'b0 && attrWr == 8'hE1, "R6", "attr write with wp",
        {23'h0, attrWeN, attrWr}, {23'h0, 1'b0, 8'hE1});
    @(negedge clk);

    // R8 ready synchronizer latency
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd0, 21'h0, 1'b0);
    devReady = '1;
    repeat (3) @(negedge clk);
    chk(cardReady == 1'b1, "R8", "all ready", {31'h0, cardReady}, 32'h1);
    devReady[13] = 1'b0;
    @(negedge clk);
    chk(cardReady == 1'b1, "R8", "one edge after busy", {31'h0, cardReady}, 32'h1);
    @(negedge clk);
    chk(cardReady == 1'b0, "R8", "two edges after busy", {31'h0, cardReady}, 32'h0);
    devReady[13] = 1'b1;
    @(negedge clk);
    chk(cardReady == 1'b0, "R8", "one edge after idle", {31'h0, cardReady}, 32'h0);
    @(negedge clk);
    chk(cardReady == 1'b1, "R8", "two edges after idle", {31'h0, cardReady}, 32'h1);
    // R10 still held after activity
    chk(waitN && bvd1 && bvd2, "R10", "wait/bvd after run", {29'h0, waitN, bvd1, bvd2}, 32'h7);

    summary();
  end

endmodule